// File: doc/BRIEF.md
# Indexed Configuration Port with Per-Device Register Banks

This block gives a host a window into the chip's configuration space through only two byte-wide bus addresses. The host first writes a register index to offset 0. It then reads or writes the byte at offset 1, and that byte access lands on the register the index names. A device-select register divides the index space into two parts. Some indices reach global registers that look the same whatever device is chosen. Other indices reach a bank of registers that belongs to the chosen logical device. Each bank holds an enable bit and a 16-bit I/O base address. Both are driven out of the block continuously, so that address decode logic elsewhere on the chip can use them.

Indices from 0xF0 upward are not stored here. They are handed to the selected device over a request/acknowledge side channel, and the host access finishes when that device answers. Every host access ends with a one-cycle `host_ack` pulse.

The sequencing is one small state machine with three states:
- `S_IDLE` waits for a request. A request goes to `S_EXT` when it is a data access at an index of 0xF0 or above; any other request goes to `S_DONE`.
- `S_EXT` holds the forwarded request and leaves for `S_DONE` when the device asserts `ext_ack`.
- `S_DONE` raises the acknowledge and always returns to `S_IDLE`.

Top module: `cfg_index_port`

## Requirements
- R1: Offset 0 (`host_addr`=0) is the index register. A write stores the byte, a read returns it, and it is 0x00 after reset.
- R2: Index 0x20 reads the chip code (`CHIP_ID`, default 0xE9) and index 0x27 reads the revision (`REV_ID`, default 0x03). Writes to either index leave the value read unchanged.
- R3: Index 0x07 is the device-select register. It is 0 after reset, it reads back its value, and a write of a value at or above `NUM_DEV` (15) is ignored.
- R4: Index 0x30 reaches the selected device's enable bit, which is bit 0 of the written byte. The bit appears on `dev_enable[d]` in the cycle of `host_ack` for that write, and it reads back as 0x00 or 0x01.
- R5: Index 0x60 reaches base address bits 15:8 and index 0x61 reaches bits 7:0 of the selected device. The address is driven on `dev_base[16*d +: 16]` and can be read back.
- R6: A write to a banked index changes only the device selected at that moment. No other device's enable bit or base address changes.
- R7: Indices 0x21–0x25, 0x28 and 0x2A–0x2D are read/write global registers, 0x00 after reset. They return the same value whichever device is selected.
- R8: Any index that is neither implemented nor forwarded reads as 0x00. A write to such an index changes no register and no output.
- R9: A data access at an index of 0xF0 or above raises `ext_req` and holds it until `ext_ack`. While the request is raised, `ext_dev` is the selected device, `ext_idx` is index bits 3:0, and `ext_wr`/`ext_wdata` repeat the host access. A forwarded read returns `ext_rdata`.
- R10: `host_ack` is a one-cycle pulse. It comes in the cycle after a locally served request, and in the cycle after `ext_ack` for a forwarded one.
- R11: After reset all `dev_enable` bits and all `dev_base` fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request, accepted in `S_IDLE` |
| host_addr | input | 1 | 0 = index register, 1 = data register |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | Access complete pulse |
| host_rdata | output | 8 | Read byte, valid with `host_ack` |
| ext_req | output | 1 | Forwarded access pending |
| ext_wr | output | 1 | Forwarded access is a write |
| ext_dev | output | DEV_W (4) | Device addressed by the forwarded access |
| ext_idx | output | 4 | Index bits 3:0 of the forwarded access |
| ext_wdata | output | 8 | Forwarded write byte |
| ext_ack | input | 1 | Device completes the forwarded access |
| ext_rdata | input | 8 | Device read byte, sampled with `ext_ack` |
| dev_enable | output | NUM_DEV (15) | Enable bit of each device |
| dev_base | output | 16*NUM_DEV (240) | Base address of each device, device d at bits 16*d+15:16*d |

## Verification
The bench builds the block with its default parameters: fifteen devices, chip code 0xE9 and revision 0x03. With these values device 14 is the highest device that can be selected, and the value 15 is the first one the select register must refuse. The bench therefore covers both the top bank and the rejected select value. A small responder model in the bench answers forwarded accesses after a fixed delay. This makes the held request, its device and index fields, and the acknowledge latency observable.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXT  = 2'd1,
        S_DONE = 2'd2
    } port_state_t;

    localparam logic [7:0] IDX_DEV_SEL   = 8'h07;
    localparam logic [7:0] IDX_CHIP_ID   = 8'h20;
    localparam logic [7:0] IDX_REVISION  = 8'h27;
    localparam logic [7:0] IDX_ENABLE    = 8'h30;
    localparam logic [7:0] IDX_BASE_HI   = 8'h60;
    localparam logic [7:0] IDX_BASE_LO   = 8'h61;
    localparam logic [7:0] IDX_EXT_FIRST = 8'hF0;

    localparam int BASE_W       = 16;
    localparam int GLOBAL_SLOTS = 10;

    // Storage slot of a global register, or -1 for other indices
    function automatic int glob_slot(input logic [7:0] idx);
        case (idx)
            8'h21:   return 0;
            8'h22:   return 1;
            8'h23:   return 2;
            8'h24:   return 3;
            8'h25:   return 4;
            8'h28:   return 5;
            8'h2A:   return 6;
            8'h2B:   return 7;
            8'h2C:   return 8;
            8'h2D:   return 9;
            default: return -1;
        endcase
    endfunction

    function automatic logic is_ext(input logic [7:0] idx);
        return idx >= IDX_EXT_FIRST;
    endfunction

endpackage

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic       host_ack,
    output logic [7:0] host_rdata,
    input  logic [7:0] loc_rdata,
    output logic [7:0] index_q,
    output logic       reg_we,
    output logic [7:0] reg_wdata,
    output logic       ext_req,
    output logic       ext_wr,
    output logic [7:0] ext_wdata,
    input  logic       ext_ack,
    input  logic [7:0] ext_rdata
);

    port_state_t state_q, state_d;
    logic        ext_wr_q;
    logic [7:0]  ext_wdata_q;
    logic [7:0]  rdata_q;
    logic        data_acc;

    assign data_acc = host_req && host_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (host_req) begin
                    if (host_addr && is_ext(index_q)) begin
                        state_d = S_EXT;
                    end else begin
                        state_d = S_DONE;
                    end
                end
            end
            S_EXT: begin
                if (ext_ack) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        host_ack  = 1'b0;
        ext_req   = 1'b0;
        reg_we    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                reg_we = data_acc && host_wr && !is_ext(index_q);
            end
            S_EXT: begin
                ext_req = 1'b1;
            end
            S_DONE: begin
                host_ack = 1'b1;
            end
            default: begin
                host_ack = 1'b0;
            end
        endcase
    end

    assign reg_wdata  = host_wdata;
    assign host_rdata = rdata_q;
    assign ext_wr     = ext_wr_q;
    assign ext_wdata  = ext_wdata_q;

    // Index, read capture and forwarded-access holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q     <= 8'h00;
            rdata_q     <= 8'h00;
            ext_wr_q    <= 1'b0;
            ext_wdata_q <= 8'h00;
        end else begin
            if (state_q == S_IDLE && host_req) begin
                if (!host_addr) begin
                    if (host_wr) begin
                        index_q <= host_wdata;
                    end else begin
                        rdata_q <= index_q;
                    end
                end else if (is_ext(index_q)) begin
                    ext_wr_q    <= host_wr;
                    ext_wdata_q <= host_wdata;
                end else if (!host_wr) begin
                    rdata_q <= loc_rdata;
                end
            end
            if (state_q == S_EXT && ext_ack && !ext_wr_q) begin
                rdata_q <= ext_rdata;
            end
        end
    end

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
    import cfg_port_pkg::*;
#(
    parameter int         NUM_DEV = 15,
    parameter int         DEV_W   = 4,
    parameter logic [7:0] CHIP_ID = 8'hE9,
    parameter logic [7:0] REV_ID  = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       index,
    input  logic             we,
    input  logic [7:0]       wdata,
    output logic [DEV_W-1:0] dev_sel,
    output logic             rd_hit,
    output logic [7:0]       rd_data
);

    logic [7:0] glob_q [GLOBAL_SLOTS];

    // Device select, out-of-range values refused
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_sel <= '0;
        end else if (we && index == IDX_DEV_SEL && int'(wdata) < NUM_DEV) begin
            dev_sel <= wdata[DEV_W-1:0];
        end
    end

    for (genvar g = 0; g < GLOBAL_SLOTS; g++) begin : g_glob
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                glob_q[g] <= 8'h00;
            end else if (we && glob_slot(index) == g) begin
                glob_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_data = 8'h00;
        if (index == IDX_DEV_SEL) begin
            rd_hit  = 1'b1;
            rd_data = 8'(dev_sel);
        end else if (index == IDX_CHIP_ID) begin
            rd_hit  = 1'b1;
            rd_data = CHIP_ID;
        end else if (index == IDX_REVISION) begin
            rd_hit  = 1'b1;
            rd_data = REV_ID;
        end else begin
            for (int g = 0; g < GLOBAL_SLOTS; g++) begin
                if (glob_slot(index) == g) begin
                    rd_hit  = 1'b1;
                    rd_data = glob_q[g];
                end
            end
        end
    end

endmodule

// File: rtl/cfg_device_bank.sv
module cfg_device_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_DEV = 15,
    parameter int DEV_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                index,
    input  logic                      we,
    input  logic [7:0]                wdata,
    input  logic [DEV_W-1:0]          dev_sel,
    output logic [NUM_DEV-1:0]        dev_enable,
    output logic [NUM_DEV*BASE_W-1:0] dev_base,
    output logic                      rd_hit,
    output logic [7:0]                rd_data
);

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic              en_q;
        logic [BASE_W-1:0] base_q;
        logic              mine;

        assign mine = we && (dev_sel == DEV_W'(d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                base_q <= '0;
            end else if (mine) begin
                if (index == IDX_ENABLE) begin
                    en_q <= wdata[0];
                end
                if (index == IDX_BASE_HI) begin
                    base_q[15:8] <= wdata;
                end
                if (index == IDX_BASE_LO) begin
                    base_q[7:0] <= wdata;
                end
            end
        end

        assign dev_enable[d]                = en_q;
        assign dev_base[d*BASE_W +: BASE_W] = base_q;
    end

    logic [BASE_W-1:0] sel_base;
    logic              sel_en;

    assign sel_base = dev_base[int'(dev_sel)*BASE_W +: BASE_W];
    assign sel_en   = dev_enable[dev_sel];

    always_comb begin
        rd_hit  = 1'b1;
        rd_data = 8'h00;
        case (index)
            IDX_ENABLE:  rd_data = {7'b0, sel_en};
            IDX_BASE_HI: rd_data = sel_base[15:8];
            IDX_BASE_LO: rd_data = sel_base[7:0];
            default:     rd_hit  = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int         NUM_DEV = 15,
    parameter logic [7:0] CHIP_ID = 8'hE9,
    parameter logic [7:0] REV_ID  = 8'h03,
    localparam int        DEV_W   = $clog2(NUM_DEV)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic                      host_addr,
    input  logic                      host_wr,
    input  logic [7:0]                host_wdata,
    output logic                      host_ack,
    output logic [7:0]                host_rdata,
    output logic                      ext_req,
    output logic                      ext_wr,
    output logic [DEV_W-1:0]          ext_dev,
    output logic [3:0]                ext_idx,
    output logic [7:0]                ext_wdata,
    input  logic                      ext_ack,
    input  logic [7:0]                ext_rdata,
    output logic [NUM_DEV-1:0]        dev_enable,
    output logic [NUM_DEV*BASE_W-1:0] dev_base
);

    logic [7:0]       index_q;
    logic             reg_we;
    logic [7:0]       reg_wdata;
    logic [7:0]       loc_rdata;
    logic [DEV_W-1:0] dev_sel;
    logic             glob_hit;
    logic [7:0]       glob_data;
    logic             bank_hit;
    logic [7:0]       bank_data;

    cfg_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .loc_rdata  (loc_rdata),
        .index_q    (index_q),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .ext_req    (ext_req),
        .ext_wr     (ext_wr),
        .ext_wdata  (ext_wdata),
        .ext_ack    (ext_ack),
        .ext_rdata  (ext_rdata)
    );

    cfg_global_regs #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W),
        .CHIP_ID (CHIP_ID),
        .REV_ID  (REV_ID)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .index   (index_q),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .dev_sel (dev_sel),
        .rd_hit  (glob_hit),
        .rd_data (glob_data)
    );

    cfg_device_bank #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .index      (index_q),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .dev_sel    (dev_sel),
        .dev_enable (dev_enable),
        .dev_base   (dev_base),
        .rd_hit     (bank_hit),
        .rd_data    (bank_data)
    );

    always_comb begin
        if (glob_hit) begin
            loc_rdata = glob_data;
        end else if (bank_hit) begin
            loc_rdata = bank_data;
        end else begin
            loc_rdata = 8'h00;
        end
    end

    assign ext_dev = dev_sel;
    assign ext_idx = index_q[3:0];

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
    parameter int NUM_DEV = 15,
    parameter int DEV_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_req,
    input logic                  host_addr,
    input logic                  host_wr,
    input logic                  host_ack,
    input logic                  ext_req,
    input logic                  ext_ack,
    input logic                  ext_wr,
    input logic [DEV_W-1:0]      ext_dev,
    input logic [3:0]            ext_idx,
    input logic [NUM_DEV-1:0]    dev_enable,
    input logic [NUM_DEV*16-1:0] dev_base
);

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R10

    AST_EXT_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_ack |=> host_ack && !ext_req); // R10

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> ext_req && $stable(ext_idx) && $stable(ext_dev) && $stable(ext_wr)); // R9

    AST_EXT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> !host_ack); // R9

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && host_addr && host_wr) |=> $stable(dev_enable) && $stable(dev_base)); // R6

endmodule

bind cfg_index_port cfg_index_port_chk #(
    .NUM_DEV (NUM_DEV),
    .DEV_W   (DEV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_ack   (host_ack),
    .ext_req    (ext_req),
    .ext_ack    (ext_ack),
    .ext_wr     (ext_wr),
    .ext_dev    (ext_dev),
    .ext_idx    (ext_idx),
    .dev_enable (dev_enable),
    .dev_base   (dev_base)
);

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

    localparam int NDEV = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_req = 1'b0;
    logic            host_addr = 1'b0;
    logic            host_wr = 1'b0;
    logic [7:0]      host_wdata = 8'h00;
    logic            host_ack;
    logic [7:0]      host_rdata;
    logic            ext_req;
    logic            ext_wr;
    logic [3:0]      ext_dev;
    logic [3:0]      ext_idx;
    logic [7:0]      ext_wdata;
    logic            ext_ack = 1'b0;
    logic [7:0]      ext_rdata = 8'h00;
    logic [NDEV-1:0] dev_enable;
    logic [NDEV*16-1:0] dev_base;

    int checks = 0;
    int errors = 0;
    int last_lat = 0;
    int ext_cnt = 0;
    logic       seen_wr = 1'b0;
    logic [7:0] seen_wdata = 8'h00;
    logic [3:0] seen_dev = 4'h0;
    logic [3:0] seen_idx = 4'h0;

    always #5 clk = ~clk;

    cfg_index_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .ext_req    (ext_req),
        .ext_wr     (ext_wr),
        .ext_dev    (ext_dev),
        .ext_idx    (ext_idx),
        .ext_wdata  (ext_wdata),
        .ext_ack    (ext_ack),
        .ext_rdata  (ext_rdata),
        .dev_enable (dev_enable),
        .dev_base   (dev_base)
    );

    // Device model for forwarded accesses: acknowledges on the second waiting cycle
    always @(negedge clk) begin
        if (ext_req && !ext_ack) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt == 2) begin
                ext_ack    = 1'b1;
                ext_rdata  = {ext_dev, ext_idx};
                seen_wr    = ext_wr;
                seen_wdata = ext_wdata;
                seen_dev   = ext_dev;
                seen_idx   = ext_idx;
            end
        end else begin
            ext_ack = 1'b0;
            ext_cnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic a, input logic w, input logic [7:0] d);
        @(negedge clk);
        host_req   = 1'b1;
        host_addr  = a;
        host_wr    = w;
        host_wdata = d;
        last_lat   = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            host_req = 1'b0;
            last_lat++;
            if (host_ack) break;
        end
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        access(1'b0, 1'b1, idx);
        access(1'b1, 1'b1, d);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
        access(1'b0, 1'b1, idx);
        access(1'b1, 1'b0, 8'h00);
        d = host_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 enables after reset", 32'(dev_enable), 32'h0);
        chk("R11 base bits after reset", 32'(|dev_base), 32'h0);
        access(1'b0, 1'b0, 8'h00);
        chk("R1 index after reset", 32'(host_rdata), 32'h00);
        rd_reg(8'h07, v);
        chk("R3 select after reset", 32'(v), 32'h00);
    endtask

    task automatic t_index();
        access(1'b0, 1'b1, 8'h5A);
        chk("R10 local latency", 32'(last_lat), 32'd1);
        access(1'b0, 1'b0, 8'h00);
        chk("R1 index readback", 32'(host_rdata), 32'h5A);
    endtask

    task automatic t_id_rev();
        logic [7:0] v;
        rd_reg(8'h20, v);
        chk("R2 chip code", 32'(v), 32'hE9);
        wr_reg(8'h20, 8'h11);
        rd_reg(8'h20, v);
        chk("R2 chip code after write", 32'(v), 32'hE9);
        wr_reg(8'h27, 8'h44);
        rd_reg(8'h27, v);
        chk("R2 revision", 32'(v), 32'h03);
    endtask

    task automatic t_select();
        logic [7:0] v;
        wr_reg(8'h07, 8'h0E);
        rd_reg(8'h07, v);
        chk("R3 select top device", 32'(v), 32'h0E);
        wr_reg(8'h07, 8'h0F);
        rd_reg(8'h07, v);
        chk("R3 select 15 refused", 32'(v), 32'h0E);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr_reg(8'h07, 8'h03);
        wr_reg(8'h30, 8'hFF);
        chk("R4 enable at ack", 32'(dev_enable), 32'h0008);
        rd_reg(8'h30, v);
        chk("R4 enable readback", 32'(v), 32'h01);
        wr_reg(8'h07, 8'h0E);
        wr_reg(8'h30, 8'h01);
        chk("R4 enable top device", 32'(dev_enable), 32'h4008);
        wr_reg(8'h30, 8'hFE);
        chk("R4 bit0 clear disables", 32'(dev_enable), 32'h0008);
    endtask

    task automatic t_base();
        logic [7:0] v;
        wr_reg(8'h07, 8'h03);
        wr_reg(8'h60, 8'h12);
        wr_reg(8'h61, 8'h34);
        chk("R5 base device 3", 32'(dev_base[3*16 +: 16]), 32'h1234);
        wr_reg(8'h07, 8'h05);
        wr_reg(8'h60, 8'hAB);
        wr_reg(8'h61, 8'hCD);
        chk("R5 base device 5", 32'(dev_base[5*16 +: 16]), 32'hABCD);
        chk("R6 device 3 untouched", 32'(dev_base[3*16 +: 16]), 32'h1234);
        chk("R6 enables untouched", 32'(dev_enable), 32'h0008);
        rd_reg(8'h61, v);
        chk("R5 low byte readback dev 5", 32'(v), 32'hCD);
        wr_reg(8'h07, 8'h03);
        rd_reg(8'h60, v);
        chk("R5 high byte readback dev 3", 32'(v), 32'h12);
        rd_reg(8'h30, v);
        chk("R6 bank switch enable", 32'(v), 32'h01);
    endtask

    task automatic t_globals();
        logic [7:0] v;
        wr_reg(8'h07, 8'h00);
        wr_reg(8'h2A, 8'h77);
        wr_reg(8'h25, 8'h55);
        wr_reg(8'h07, 8'h09);
        rd_reg(8'h2A, v);
        chk("R7 global 0x2A other bank", 32'(v), 32'h77);
        rd_reg(8'h25, v);
        chk("R7 global 0x25 other bank", 32'(v), 32'h55);
        rd_reg(8'h28, v);
        chk("R7 global 0x28 reset", 32'(v), 32'h00);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        wr_reg(8'h26, 8'h99);
        rd_reg(8'h26, v);
        chk("R8 index 0x26 reads zero", 32'(v), 32'h00);
        wr_reg(8'h07, 8'h03);
        wr_reg(8'h40, 8'h00);
        chk("R8 write 0x40 no enable change", 32'(dev_enable), 32'h0008);
        chk("R8 write 0x40 no base change", 32'(dev_base[3*16 +: 16]), 32'h1234);
        rd_reg(8'h40, v);
        chk("R8 index 0x40 reads zero", 32'(v), 32'h00);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        wr_reg(8'h07, 8'h05);
        wr_reg(8'hF3, 8'h6C);
        chk("R9 forwarded write flag", 32'(seen_wr), 32'h1);
        chk("R9 forwarded write data", 32'(seen_wdata), 32'h6C);
        chk("R9 forwarded device", 32'(seen_dev), 32'h5);
        chk("R9 forwarded index", 32'(seen_idx), 32'h3);
        chk("R10 forwarded latency", 32'(last_lat), 32'd3);
        rd_reg(8'hFF, v);
        chk("R9 forwarded read data", 32'(v), 32'h5F);
        chk("R9 forwarded read flag", 32'(seen_wr), 32'h0);
        chk("R9 no side effect on bank", 32'(dev_base[5*16 +: 16]), 32'hABCD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_id_rev();
        t_select();
        t_enable();
        t_base();
        t_globals();
        t_unimpl();
        t_ext();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule